// File: doc/BRIEF.md
# AXI4-Lite to APB Register Bridge

This block connects a 32-bit AXI4-Lite manager to a register target on an APB3 port. It takes one AXI4-Lite read or write at a time. Each transfer is turned into an APB setup cycle followed by an access phase. The access phase lasts until the target raises PREADY. The bridge then returns the write response or the read data on the AXI side. The AXI side and the APB side run on the same clock.

A watchdog limits how long an access phase may wait for PREADY. When a transfer runs past that limit, the bridge abandons it and answers with an error response. It then raises a sticky error output and accepts no more work until it is reset. The same error output also latches when the manager breaks the AXI handshake rules. An error response from the target is only forwarded in BRESP or RRESP; it does not touch the error output. The reset is synchronous and active low, and it abandons any transfer in progress.

Top module: `axil_apb_bridge`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `psel`, `penable`, `bvalid`, `rvalid` and `bus_err` are low, and no ready is raised while no valid is present.
- R2: A write is accepted only in a cycle where `awvalid` and `wvalid` are both high. Both readies rise together in that cycle. The next cycle is an APB setup cycle: `psel`=1, `penable`=0, `pwrite`=1, with the captured `paddr`, `pwdata` and `pstrb`. The cycle after that has `penable`=1.
- R3: A read accepted on AR produces an APB setup cycle with `pwrite`=0 and `paddr` equal to `araddr`, then an access phase. `rdata` returns the value of `prdata` sampled with PREADY, and `rresp` is OKAY (2'b00).
- R4: `bvalid`/`bresp` and `rvalid`/`rresp`/`rdata` stay unchanged until `bready`/`rready` is high. No new transfer is accepted while a response is waiting. Only one APB transfer is ever outstanding.
- R5: If AW and W are both valid in the same cycle as AR, the write is served first. `arready` stays low in that cycle.
- R6: When the target completes with `pslverr`=1, the response is SLVERR (2'b10) and `bus_err` stays low.
- R7: An access phase with no PREADY for `TIMEOUT_CYCLES` cycles (default 256) is dropped. `psel`/`penable` fall, the response is SLVERR, read data is zero, and `bus_err` rises.
- R8: After a timeout, `awready`, `wready` and `arready` stay low and `bus_err` stays high until reset. After reset the bridge works again.
- R9: If `awvalid`, `wvalid` or `arvalid` falls before its handshake completes, `bus_err` goes high from the next clock edge and stays high until reset. Transfers continue to work normally.
- R10: While an access phase waits for PREADY, `paddr`, `pwrite` and `pwdata` hold steady. An access to an address the target does not map completes with OKAY and leaves `bus_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bresp | output | 2 | Write response |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response taken |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data taken |
| paddr | output | ADDR_W | APB address |
| psel | output | 1 | APB select |
| penable | output | 1 | APB access phase |
| pwrite | output | 1 | APB direction, 1 for write |
| pwdata | output | 32 | APB write data |
| pstrb | output | 4 | APB write strobes |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB transfer complete |
| pslverr | input | 1 | APB target error |
| bus_err | output | 1 | Sticky protocol or timeout error |

## Verification
Some internal faults show up within one or two cycles. A wrong sequencer state gives a setup cycle without an access cycle, a transfer that starts before the previous response has gone out, or an acceptance in the halted state. A wrong watchdog count only becomes visible at the end of a stalled access phase, so the access phase is measured cycle by cycle against `TIMEOUT_CYCLES`. A lost or wrongly merged write stays hidden until a later read of the same register. The random sequence therefore keeps a bench model of the register file and checks every read against it.

// File: rtl/bridge_pkg.sv
// Shared types for the AXI4-Lite to APB bridge.
// Assumes: a single clock domain; the encodings here are used by every module.
package bridge_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_RESP,
        ST_HALT
    } br_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/bridge_arb.sv
// Picks which pending AXI request enters the APB sequencer.
// A write needs both AW and W valid; it beats a read in the same cycle.
// Assumes: enable is high only while the sequencer is idle.
module bridge_arb (
    input  logic enable,
    input  logic aw_valid,
    input  logic w_valid,
    input  logic ar_valid,
    output logic grant_wr,
    output logic grant_rd
);
    logic wr_ready_pair;

    // Write-first grant decision
    always_comb begin
        wr_ready_pair = aw_valid && w_valid;
        grant_wr      = enable && wr_ready_pair;
        grant_rd      = enable && ar_valid && !wr_ready_pair;
    end
endmodule

// File: rtl/bridge_proto_mon.sv
// Flags a valid that is withdrawn before its handshake completes.
// Watches NCH channels; viol pulses in the cycle the drop is seen.
// Assumes: valid and ready are sampled on the same clock as the bridge.
module bridge_proto_mon #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] valid,
    input  logic [NCH-1:0] ready,
    output logic           viol
);
    logic [NCH-1:0] drop;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic waiting_q;

            // Remember that this channel was offered but not taken
            always_ff @(posedge clk) begin
                if (!rst_n) waiting_q <= 1'b0;
                else        waiting_q <= valid[i] && !ready[i];
            end

            assign drop[i] = waiting_q && !valid[i];
        end
    endgenerate

    assign viol = |drop;

    // R9
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(|(valid & ~ready)));
endmodule

// File: rtl/bridge_watchdog.sv
// Counts access-phase cycles that pass without PREADY.
// expire is high in the last allowed cycle; the sequencer then drops the transfer.
// Assumes: run falls as soon as the access phase ends.
module bridge_watchdog #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == CW'(LIMIT - 1));

    // Advance while waiting, restart whenever the wait ends
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    // R7
    wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/axil_apb_bridge.sv
// AXI4-Lite subordinate to APB3 manager bridge, one transfer at a time.
// Converts each accepted read or write into an APB setup + access sequence,
// bounds the access phase with a watchdog, and latches a sticky error on
// timeout or on an AXI handshake violation. A timeout halts the bridge
// until reset. Assumes: AXI and APB share clk; rst_n is synchronous.
module axil_apb_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int DATA_W         = 32,
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                awvalid,
    output logic                awready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wvalid,
    output logic                wready,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic                arvalid,
    output logic                arready,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                rvalid,
    input  logic                rready,
    output logic [ADDR_W-1:0]   paddr,
    output logic                psel,
    output logic                penable,
    output logic                pwrite,
    output logic [DATA_W-1:0]   pwdata,
    output logic [DATA_W/8-1:0] pstrb,
    input  logic [DATA_W-1:0]   prdata,
    input  logic                pready,
    input  logic                pslverr,
    output logic                bus_err
);
    localparam int STRB_W = DATA_W / 8;

    br_state_e           state_q, state_d;
    logic                grant_wr, grant_rd;
    logic                wd_run, wd_expire, viol;
    logic                err_q, timed_q;
    logic                is_wr_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q, rdata_q;
    logic [STRB_W-1:0]   strb_q;
    logic [1:0]          resp_q;
    logic                resp_taken;

    bridge_arb i_arb (
        .enable   (state_q == ST_IDLE),
        .aw_valid (awvalid),
        .w_valid  (wvalid),
        .ar_valid (arvalid),
        .grant_wr (grant_wr),
        .grant_rd (grant_rd)
    );

    assign wd_run = (state_q == ST_ACCESS) && !pready;

    bridge_watchdog #(.LIMIT(TIMEOUT_CYCLES)) i_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wd_run),
        .expire (wd_expire)
    );

    bridge_proto_mon #(.NCH(3)) i_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .valid ({awvalid, wvalid, arvalid}),
        .ready ({awready, wready, arready}),
        .viol  (viol)
    );

    assign resp_taken = is_wr_q ? bready : rready;

    // Sequencer next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (grant_wr || grant_rd) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ACCESS;
            ST_ACCESS: if (pready || wd_expire) state_d = ST_RESP;
            ST_RESP:   if (resp_taken) state_d = timed_q ? ST_HALT : ST_IDLE;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the granted request for the APB side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            strb_q  <= '0;
            is_wr_q <= 1'b0;
        end else if (grant_wr) begin
            addr_q  <= awaddr;
            wdata_q <= wdata;
            strb_q  <= wstrb;
            is_wr_q <= 1'b1;
        end else if (grant_rd) begin
            addr_q  <= araddr;
            strb_q  <= '0;
            is_wr_q <= 1'b0;
        end
    end

    // Record the outcome of the access phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q  <= RESP_OKAY;
            rdata_q <= '0;
        end else if (state_q == ST_ACCESS) begin
            if (pready) begin
                resp_q  <= pslverr ? RESP_SLVERR : RESP_OKAY;
                rdata_q <= is_wr_q ? '0 : prdata;
            end else if (wd_expire) begin
                resp_q  <= RESP_SLVERR;
                rdata_q <= '0;
            end
        end
    end

    // Sticky error and halt flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            timed_q <= 1'b0;
        end else begin
            err_q   <= err_q || viol || wd_expire;
            timed_q <= timed_q || wd_expire;
        end
    end

    assign awready = grant_wr;
    assign wready  = grant_wr;
    assign arready = grant_rd;
    assign psel    = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
    assign penable = (state_q == ST_ACCESS);
    assign pwrite  = is_wr_q;
    assign paddr   = addr_q;
    assign pwdata  = wdata_q;
    assign pstrb   = strb_q;
    assign bvalid  = (state_q == ST_RESP) && is_wr_q;
    assign rvalid  = (state_q == ST_RESP) && !is_wr_q;
    assign bresp   = resp_q;
    assign rresp   = resp_q;
    assign rdata   = rdata_q;
    assign bus_err = err_q;

    // R2
    setup_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !penable |=> psel && penable);

    // R10
    apb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && !pready && !wd_expire |=>
            psel && $stable(paddr) && $stable(pwrite) && $stable(pwdata));

    // R4
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid && $stable(bresp));

    // R4
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rresp) && $stable(rdata));

    // R4
    single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid || rvalid) |-> !(psel || awready || arready));

    // R5
    write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arready |-> !(awvalid && wvalid));

    // R7
    timeout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> !psel && (bvalid || rvalid) && bus_err);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> bus_err);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> !(awready || wready || arready || psel));
endmodule

// File: tb/test_axil_apb_bridge.sv
`timescale 1ns/100ps
module test_axil_apb_bridge;
    localparam int TO = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] awaddr = '0, araddr = '0, paddr;
    logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic        bready = 1'b0, rready = 1'b0;
    logic [31:0] wdata = '0, rdata, pwdata, prdata;
    logic [3:0]  wstrb = '0, pstrb;
    logic        awready, wready, arready, bvalid, rvalid;
    logic [1:0]  bresp, rresp;
    logic        psel, penable, pwrite, pready, pslverr, bus_err;

    int checks = 0, fails = 0;
    int acc_cnt = 0;
    int wcnt = 0, twait = 0;
    bit stall = 1'b0;
    bit done = 1'b0;
    logic [31:0] tmem [16];
    logic [31:0] model [16];

    always #2 clk = ~clk;

    axil_apb_bridge #(.ADDR_W(12), .DATA_W(32), .TIMEOUT_CYCLES(TO)) i_axil_apb_bridge (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite),
        .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .bus_err(bus_err)
    );

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] s);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    function automatic bit mapped(input logic [11:0] a);
        return a[11:6] == 6'd0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // APB target model: random wait, 16 mapped words, error at 0xFF0
    initial begin
        pready = 1'b0; prdata = '0; pslverr = 1'b0;
        for (int i = 0; i < 16; i++) tmem[i] = '0;
        forever begin
            @(negedge clk);
            if (psel && penable) acc_cnt++;
            if (psel && penable && !stall) begin
                if (wcnt >= twait) begin
                    pready  = 1'b1;
                    pslverr = (paddr == 12'hFF0);
                    if (pwrite) begin
                        if (mapped(paddr)) tmem[paddr[5:2]] = merge(tmem[paddr[5:2]], pwdata, pstrb);
                        prdata = '0;
                    end else begin
                        prdata = mapped(paddr) ? tmem[paddr[5:2]] : 32'd0;
                    end
                    wcnt = 0;
                    twait = $urandom % 4;
                end else begin
                    pready = 1'b0;
                    wcnt++;
                end
            end else begin
                pready = 1'b0; pslverr = 1'b0; wcnt = 0;
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #0.5;
        chk("R1 reset outputs", {psel, penable, bvalid, rvalid, bus_err, awready, arready}, 7'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk("R1 first cycle", {psel, penable, bvalid, rvalid, bus_err}, 5'd0);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s,
                            input int hold, output logic [1:0] r);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
        #0.5;
        while (!(awready && wready)) begin @(negedge clk); #0.5; end
        if (arvalid) chk("R5 read waits", arready, 1'b0);
        @(posedge clk); @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        chk("R2 setup phase", {psel, penable, pwrite}, 3'b101);
        chk("R2 setup addr/data", {paddr, pwdata, pstrb}, {a, d, s});
        @(negedge clk);
        chk("R2 access phase", {psel, penable}, 2'b11);
        #0.5;
        while (!bvalid) begin @(negedge clk); #0.5; end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk); #0.5;
            chk("R4 bvalid held", {bvalid, bresp}, {1'b1, r_prev(bresp)});
            if (arvalid) chk("R4 no accept while waiting", {arready, psel}, 2'b00);
        end
        bready = 1'b1;
        #0.5;
        r = bresp;
        @(posedge clk); @(negedge clk);
        bready = 1'b0;
    endtask

    function automatic logic [1:0] r_prev(input logic [1:0] x);
        return x;
    endfunction

    task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic [1:0] r);
        araddr = a; arvalid = 1'b1;
        #0.5;
        while (!arready) begin @(negedge clk); #0.5; end
        @(posedge clk); @(negedge clk);
        arvalid = 1'b0;
        chk("R3 setup phase", {psel, penable, pwrite, paddr}, {3'b100, a});
        rready = 1'b1;
        #0.5;
        while (!rvalid) begin @(negedge clk); #0.5; end
        d = rdata; r = rresp;
        @(posedge clk); @(negedge clk);
        rready = 1'b0;
    endtask

    // Watchdog for the bench itself
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0]  r;
        logic [31:0] d;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) model[i] = '0;
        @(negedge clk);
        do_reset();

        // R2 / R3 directed pair
        do_write(12'h004, 32'hA5A5_1234, 4'hF, 0, r);
        chk("R2 bresp", r, 2'b00);
        model[1] = 32'hA5A5_1234;
        do_read(12'h004, d, r);
        chk("R3 rdata", d, 32'hA5A5_1234);
        chk("R3 rresp", r, 2'b00);

        // R5 + R4: write and read offered together, response held back
        arvalid = 1'b1; araddr = 12'h008;
        do_write(12'h008, 32'h0BAD_F00D, 4'b0101, 3, r);
        model[2] = merge(model[2], 32'h0BAD_F00D, 4'b0101);
        do_read(12'h008, d, r);
        chk("R5 read after write", d, model[2]);

        // R6: target error forwarded, no sticky error
        do_write(12'hFF0, 32'h1, 4'hF, 0, r);
        chk("R6 bresp slverr", r, 2'b10);
        do_read(12'hFF0, d, r);
        chk("R6 rresp slverr", r, 2'b10);
        chk("R6 bus_err low", bus_err, 1'b0);

        // R10: unmapped address completes OKAY
        do_write(12'h840, 32'h77, 4'hF, 0, r);
        chk("R10 unmapped bresp", r, 2'b00);
        do_read(12'h840, d, r);
        chk("R10 unmapped rresp", {r, d}, {2'b00, 32'd0});
        chk("R10 bus_err low", bus_err, 1'b0);

        // Random mix against the register model
        for (int n = 0; n < 150; n++) begin
            logic [11:0] a;
            logic [31:0] v;
            logic [3:0]  s;
            a = ($urandom % 4 == 0) ? {4'h8, 6'($urandom), 2'b00} : {6'd0, 4'($urandom), 2'b00};
            if ($urandom % 2 == 1) begin
                v = $urandom; s = 4'($urandom);
                do_write(a, v, s, $urandom % 2, r);
                if (mapped(a)) model[a[5:2]] = merge(model[a[5:2]], v, s);
                chk("R2 random bresp", r, 2'b00);
            end else begin
                do_read(a, d, r);
                chk("R3 random rdata", {r, d}, {2'b00, mapped(a) ? model[a[5:2]] : 32'd0});
            end
        end

        // R9: AW withdrawn before handshake
        awvalid = 1'b1; awaddr = 12'h010;
        @(negedge clk);
        awvalid = 1'b0;
        @(negedge clk);
        chk("R9 violation flagged", bus_err, 1'b1);
        do_write(12'h00C, 32'hCAFE_0001, 4'hF, 0, r);
        chk("R9 still operates", r, 2'b00);
        model[3] = 32'hCAFE_0001;
        chk("R9 error sticky", bus_err, 1'b1);
        do_reset();
        for (int i = 0; i < 16; i++) tmem[i] = model[i];

        // R7: stalled read times out
        stall = 1'b1;
        acc_cnt = 0;
        do_read(12'h004, d, r);
        chk("R7 access length", acc_cnt, TO);
        chk("R7 rresp slverr", r, 2'b10);
        chk("R7 rdata zero", d, 32'd0);
        chk("R7 bus_err high", bus_err, 1'b1);

        // R8: halted until reset
        stall = 1'b0;
        awvalid = 1'b1; wvalid = 1'b1; arvalid = 1'b1;
        for (int k = 0; k < 5; k++) begin
            #0.5;
            chk("R8 no accept when halted", {awready, wready, arready, psel}, 4'b0000);
            @(negedge clk);
        end
        awvalid = 1'b0; wvalid = 1'b0; arvalid = 1'b0;
        @(negedge clk);
        chk("R8 error held", bus_err, 1'b1);
        do_reset();
        do_read(12'h004, d, r);
        chk("R8 works after reset", {r, d}, {2'b00, model[1]});
        chk("R8 error cleared", bus_err, 1'b0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule